// File: doc/BRIEF.md
# Eight-Bit Arithmetic and Logic Unit with Status Flags

This block is the purely combinational datapath of a small eight-bit processor core. It takes the accumulator, a second operand, an incoming carry, the current status byte and a four-bit operation code. In the same cycle it returns an eight-bit result, a strobe that says whether that result should be written back to the accumulator, and the updated status byte.

Each operation rewrites only its own subset of the six defined flags. Every other bit of the status byte, including the two undefined bits 5 and 3, is copied from the incoming byte. Arithmetic and logic operations share a single adder/subtractor and a single bitwise unit. The P/V position holds signed overflow for arithmetic operations and even parity for bitwise operations.

Top module: `alu8_core`

## Requirements
- R1: Status byte layout: sign = bit 7, zero = bit 6, half-carry = bit 4, P/V = bit 2, subtract (N) = bit 1, carry = bit 0. Bits 5 and 3 of `flags_o` always equal the same bits of `flags_i`.
- R2: Add (op 0) and add-with-carry (op 1, which adds `carry_i`) write the sum. They set S from bit 7 and Z on a zero result, H on a carry out of bit 3, P/V on signed overflow and C on a carry out of bit 7, and they clear N.
- R3: Subtract (op 2) and subtract-with-borrow (op 3, which also subtracts `carry_i`) write A minus the operand. They set S and Z as for add, set H on a borrow from bit 4, P/V on signed overflow and C on a borrow from bit 8, and they set N.
- R4: Compare (op 4) produces the same flags as subtract. It drives `wr_en_o` low and presents the unchanged accumulator on `result_o`.
- R5: AND (op 5), OR (op 6) and XOR (op 7) write the bitwise result and set S and Z from it. P/V is set when the result has an even number of ones. H is 1 for AND and 0 for OR and XOR. N and C are cleared.
- R6: Increment (op 8) and decrement (op 9) write A plus one or A minus one. They update S, Z, H and P/V (as overflow), clear N on increment and set N on decrement, and copy C from `flags_i`.
- R7: Negate (op 10) writes 0 minus A and sets its flags as subtract does. A = 0x80 gives overflow, any nonzero A gives carry, and N is set.
- R8: Complement (op 11) writes the bitwise inverse of A. It sets H and N and leaves S, Z, P/V and C as they arrive.
- R9: Set-carry (op 12) forces C to 1 and clears H and N. Complement-carry (op 13) sets C to the inverse of `carry_i`, sets H to `carry_i` and clears N. Both leave S, Z and P/V unchanged, drive `wr_en_o` low and present A on `result_o`.
- R10: Codes 14 and 15 are no-ops. `wr_en_o` is low, `result_o` equals A and `flags_o` equals `flags_i`.
- R11: Add, subtract, increment and decrement ignore `carry_i`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| acc_i | input | 8 | Accumulator value |
| opnd_i | input | 8 | Second operand |
| carry_i | input | 1 | Incoming carry/borrow for ADC, SBC and CCF |
| flags_i | input | 8 | Current status byte |
| op_i | input | 4 | Operation code (0..15) |
| result_o | output | 8 | Computed result |
| wr_en_o | output | 1 | High when the result is to be written to A |
| flags_o | output | 8 | Updated status byte |

## Verification
The operands are chosen at the nibble and sign boundaries: 0x0F+1, 0x7F+1, 0xFF+1, 0x80-1 and 0-0 with borrow. These values separate half-carry from full carry and signed overflow from unsigned carry, in both the add and the subtract direction. Increment and decrement are run with the incoming carry both set and clear, which shows that carry is really preserved and not simply forced to a constant. Logic operands are picked so that parity comes out even in one case and odd in another. The incoming status bytes carry set bits in the positions an operation must leave untouched, so a stray write to any of those positions shows up. Compare, set-carry, complement-carry and the spare codes are checked for a low write strobe.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

    localparam int DW = 8;

    localparam int FL_S  = 7;
    localparam int FL_Z  = 6;
    localparam int FL_H  = 4;
    localparam int FL_PV = 2;
    localparam int FL_N  = 1;
    localparam int FL_C  = 0;

    typedef enum logic [3:0] {
        OP_ADD = 4'd0,
        OP_ADC = 4'd1,
        OP_SUB = 4'd2,
        OP_SBC = 4'd3,
        OP_CP  = 4'd4,
        OP_AND = 4'd5,
        OP_OR  = 4'd6,
        OP_XOR = 4'd7,
        OP_INC = 4'd8,
        OP_DEC = 4'd9,
        OP_NEG = 4'd10,
        OP_CPL = 4'd11,
        OP_SCF = 4'd12,
        OP_CCF = 4'd13,
        OP_RS0 = 4'd14,
        OP_RS1 = 4'd15
    } alu_op_e;

    typedef enum logic [1:0] {
        LG_AND = 2'd0,
        LG_OR  = 2'd1,
        LG_XOR = 2'd2
    } logic_sel_e;

    typedef struct packed {
        logic [DW-1:0] sum;
        logic          cy;
        logic          hc;
        logic          ov;
    } arith_out_t;

    function automatic logic even_parity(input logic [DW-1:0] v);
        return ~(^v);
    endfunction

endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub #(
    parameter int W = 8
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         cin_i,
    input  logic         sub_i,
    output logic [W-1:0] sum_o,
    output logic         cy_o,
    output logic         hc_o,
    output logic         ov_o
);
    localparam int HW = W / 2;

    logic [W-1:0] b_eff;
    logic         c_eff;
    logic [HW:0]  low_sum;
    logic [W:0]   full_sum;

    always_comb begin
        b_eff    = sub_i ? ~b_i : b_i;
        c_eff    = sub_i ? ~cin_i : cin_i;
        low_sum  = {1'b0, a_i[HW-1:0]} + {1'b0, b_eff[HW-1:0]} + {{HW{1'b0}}, c_eff};
        full_sum = {1'b0, a_i} + {1'b0, b_eff} + {{W{1'b0}}, c_eff};
        sum_o    = full_sum[W-1:0];
        cy_o     = full_sum[W] ^ sub_i;
        hc_o     = low_sum[HW] ^ sub_i;
        ov_o     = (a_i[W-1] == b_eff[W-1]) && (full_sum[W-1] != a_i[W-1]);
    end
endmodule

// File: rtl/alu8_bitwise.sv
module alu8_bitwise
    import alu8_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic_sel_e   sel_i,
    output logic [W-1:0] y_o
);
    always_comb begin
        unique case (sel_i)
            LG_AND:  y_o = a_i & b_i;
            LG_OR:   y_o = a_i | b_i;
            LG_XOR:  y_o = a_i ^ b_i;
            default: y_o = a_i ^ b_i;
        endcase
    end
endmodule

// File: rtl/alu8_core.sv
module alu8_core
    import alu8_pkg::*;
(
    input  logic [7:0] acc_i,
    input  logic [7:0] opnd_i,
    input  logic       carry_i,
    input  logic [7:0] flags_i,
    input  logic [3:0] op_i,
    output logic [7:0] result_o,
    output logic       wr_en_o,
    output logic [7:0] flags_o
);
    localparam logic [DW-1:0] ONE = {{(DW-1){1'b0}}, 1'b1};

    alu_op_e     op;
    logic [DW-1:0] add_a, add_b;
    logic          add_cin, add_sub;
    arith_out_t    ar;
    logic_sel_e    lsel;
    logic [DW-1:0] lres;

    assign op = alu_op_e'(op_i);

    // operand routing into the shared adder
    always_comb begin
        add_a   = acc_i;
        add_b   = opnd_i;
        add_cin = 1'b0;
        add_sub = 1'b0;
        unique case (op)
            OP_ADC: add_cin = carry_i;
            OP_SUB, OP_CP: add_sub = 1'b1;
            OP_SBC: begin add_sub = 1'b1; add_cin = carry_i; end
            OP_INC: add_b = ONE;
            OP_DEC: begin add_b = ONE; add_sub = 1'b1; end
            OP_NEG: begin add_a = '0; add_b = acc_i; add_sub = 1'b1; end
            default: ;
        endcase
    end

    alu8_addsub #(.W(DW)) u_addsub (
        .a_i   (add_a),
        .b_i   (add_b),
        .cin_i (add_cin),
        .sub_i (add_sub),
        .sum_o (ar.sum),
        .cy_o  (ar.cy),
        .hc_o  (ar.hc),
        .ov_o  (ar.ov)
    );

    always_comb begin
        unique case (op)
            OP_OR:   lsel = LG_OR;
            OP_XOR:  lsel = LG_XOR;
            default: lsel = LG_AND;
        endcase
    end

    alu8_bitwise #(.W(DW)) u_bitwise (
        .a_i   (acc_i),
        .b_i   (opnd_i),
        .sel_i (lsel),
        .y_o   (lres)
    );

    // result, strobe and flag formation
    always_comb begin
        result_o = acc_i;
        wr_en_o  = 1'b0;
        flags_o  = flags_i;
        unique case (op)
            OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_CP, OP_INC, OP_DEC, OP_NEG: begin
                flags_o[FL_S]  = ar.sum[DW-1];
                flags_o[FL_Z]  = (ar.sum == '0);
                flags_o[FL_H]  = ar.hc;
                flags_o[FL_PV] = ar.ov;
                flags_o[FL_N]  = add_sub;
                if (op != OP_INC && op != OP_DEC) flags_o[FL_C] = ar.cy;
                if (op != OP_CP) begin
                    result_o = ar.sum;
                    wr_en_o  = 1'b1;
                end
            end
            OP_AND, OP_OR, OP_XOR: begin
                result_o       = lres;
                wr_en_o        = 1'b1;
                flags_o[FL_S]  = lres[DW-1];
                flags_o[FL_Z]  = (lres == '0);
                flags_o[FL_H]  = (op == OP_AND);
                flags_o[FL_PV] = even_parity(lres);
                flags_o[FL_N]  = 1'b0;
                flags_o[FL_C]  = 1'b0;
            end
            OP_CPL: begin
                result_o      = ~acc_i;
                wr_en_o       = 1'b1;
                flags_o[FL_H] = 1'b1;
                flags_o[FL_N] = 1'b1;
            end
            OP_SCF: begin
                flags_o[FL_C] = 1'b1;
                flags_o[FL_H] = 1'b0;
                flags_o[FL_N] = 1'b0;
            end
            OP_CCF: begin
                flags_o[FL_C] = ~carry_i;
                flags_o[FL_H] = carry_i;
                flags_o[FL_N] = 1'b0;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/alu8_core_chk.sv
module alu8_core_chk (
    input logic [7:0] acc_i,
    input logic [3:0] op_i,
    input logic [7:0] flags_i,
    input logic [7:0] result_o,
    input logic       wr_en_o,
    input logic [7:0] flags_o
);
    always_comb begin
        assert_passbits_R1: assert ((flags_o[5] == flags_i[5]) && (flags_o[3] == flags_i[3]))
            else $error("bits 5/3 not passed through");
        if (op_i == 4'd4) begin
            assert_cp_nowrite_R4: assert (!wr_en_o && (result_o == acc_i))
                else $error("compare wrote accumulator");
        end
        if (op_i >= 4'd5 && op_i <= 4'd7) begin
            assert_logic_nc_R5: assert (!flags_o[1] && !flags_o[0])
                else $error("logic op left N or C set");
        end
        if (op_i == 4'd8 || op_i == 4'd9) begin
            assert_incdec_carry_R6: assert (flags_o[0] == flags_i[0])
                else $error("inc/dec changed carry");
        end
        if (op_i == 4'd11) begin
            assert_cpl_result_R8: assert (wr_en_o && (result_o == ~acc_i))
                else $error("complement result wrong");
        end
        if (op_i >= 4'd14) begin
            assert_spare_noop_R10: assert (!wr_en_o && (flags_o == flags_i) && (result_o == acc_i))
                else $error("spare code not a no-op");
        end
        if (wr_en_o && op_i != 4'd11) begin
            assert_zero_flag_R2: assert (flags_o[6] == (result_o == 8'h00))
                else $error("zero flag disagrees with result");
        end
    end
endmodule

bind alu8_core alu8_core_chk u_chk (
    .acc_i    (acc_i),
    .op_i     (op_i),
    .flags_i  (flags_i),
    .result_o (result_o),
    .wr_en_o  (wr_en_o),
    .flags_o  (flags_o)
);

// File: tb/alu8_core_bench.sv
module alu8_core_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] acc_i = '0, opnd_i = '0, flags_i = '0;
    logic       carry_i = 1'b0;
    logic [3:0] op_i = '0;
    logic [7:0] result_o, flags_o;
    logic       wr_en_o;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    alu8_core u_alu8_core (
        .acc_i    (acc_i),
        .opnd_i   (opnd_i),
        .carry_i  (carry_i),
        .flags_i  (flags_i),
        .op_i     (op_i),
        .result_o (result_o),
        .wr_en_o  (wr_en_o),
        .flags_o  (flags_o)
    );

    // {req, op, acc, opnd, cin, fin, res, we, fout}
    localparam int NV = 25;
    localparam logic [49:0] VEC [0:NV-1] = '{
        {4'd2,  4'd0,  8'h0F, 8'h01, 1'b0, 8'h00, 8'h10, 1'b1, 8'h10}, // R2 half carry
        {4'd2,  4'd0,  8'h7F, 8'h01, 1'b0, 8'h00, 8'h80, 1'b1, 8'h94}, // R2 overflow
        {4'd2,  4'd0,  8'hFF, 8'h01, 1'b0, 8'h00, 8'h00, 1'b1, 8'h51}, // R2 carry, zero
        {4'd2,  4'd1,  8'h10, 8'h20, 1'b1, 8'h00, 8'h31, 1'b1, 8'h00}, // R2 adc
        {4'd3,  4'd2,  8'h10, 8'h01, 1'b0, 8'h00, 8'h0F, 1'b1, 8'h12}, // R3 half borrow
        {4'd3,  4'd2,  8'h80, 8'h01, 1'b0, 8'h00, 8'h7F, 1'b1, 8'h16}, // R3 overflow
        {4'd3,  4'd3,  8'h00, 8'h00, 1'b1, 8'h00, 8'hFF, 1'b1, 8'h93}, // R3 sbc borrow
        {4'd4,  4'd4,  8'h42, 8'h42, 1'b0, 8'h00, 8'h42, 1'b0, 8'h42}, // R4 equal
        {4'd4,  4'd4,  8'h10, 8'h20, 1'b0, 8'h00, 8'h10, 1'b0, 8'h83}, // R4 less
        {4'd5,  4'd5,  8'hF0, 8'h3C, 1'b0, 8'h01, 8'h30, 1'b1, 8'h14}, // R5 and
        {4'd5,  4'd6,  8'h00, 8'h00, 1'b0, 8'h13, 8'h00, 1'b1, 8'h44}, // R5 or
        {4'd5,  4'd7,  8'hFF, 8'h01, 1'b0, 8'h00, 8'hFE, 1'b1, 8'h80}, // R5 xor odd
        {4'd6,  4'd8,  8'h7F, 8'h00, 1'b0, 8'h01, 8'h80, 1'b1, 8'h95}, // R6 inc keeps C=1
        {4'd6,  4'd8,  8'hFF, 8'h00, 1'b0, 8'h00, 8'h00, 1'b1, 8'h50}, // R6 inc keeps C=0
        {4'd6,  4'd9,  8'h00, 8'h00, 1'b0, 8'h01, 8'hFF, 1'b1, 8'h93}, // R6 dec wrap
        {4'd6,  4'd9,  8'h80, 8'h00, 1'b0, 8'h00, 8'h7F, 1'b1, 8'h16}, // R6 dec overflow
        {4'd7,  4'd10, 8'h80, 8'h00, 1'b0, 8'h00, 8'h80, 1'b1, 8'h87}, // R7 neg 0x80
        {4'd7,  4'd10, 8'h01, 8'h00, 1'b0, 8'h00, 8'hFF, 1'b1, 8'h93}, // R7 neg 1
        {4'd7,  4'd10, 8'h00, 8'h00, 1'b0, 8'h00, 8'h00, 1'b1, 8'h42}, // R7 neg 0
        {4'd8,  4'd11, 8'h5A, 8'h00, 1'b0, 8'hC5, 8'hA5, 1'b1, 8'hD7}, // R8 cpl
        {4'd9,  4'd12, 8'h33, 8'h00, 1'b0, 8'hD6, 8'h33, 1'b0, 8'hC5}, // R9 scf
        {4'd9,  4'd13, 8'h33, 8'h00, 1'b1, 8'h03, 8'h33, 1'b0, 8'h10}, // R9 ccf from 1
        {4'd1,  4'd0,  8'h01, 8'h01, 1'b0, 8'h28, 8'h02, 1'b1, 8'h28}, // R1 bits 5/3
        {4'd10, 4'd14, 8'h55, 8'h00, 1'b0, 8'hAB, 8'h55, 1'b0, 8'hAB}, // R10 code 14
        {4'd10, 4'd15, 8'h99, 8'h00, 1'b1, 8'h00, 8'h99, 1'b0, 8'h00}  // R10 code 15
    };

    task automatic check(input int req, input logic [7:0] r, input logic w, input logic [7:0] f);
        n_run++;
        if (result_o !== r || wr_en_o !== w || flags_o !== f) begin
            n_fail++;
            $display("FAIL R%0d: got res=%h we=%b flags=%h, expected res=%h we=%b flags=%h",
                     req, result_o, wr_en_o, flags_o, r, w, f);
        end
    endtask

    task automatic drive(input logic [3:0] op, input logic [7:0] a, input logic [7:0] b,
                         input logic c, input logic [7:0] fi);
        @(negedge clk);
        op_i = op; acc_i = a; opnd_i = b; carry_i = c; flags_i = fi;
        #1;
    endtask

    initial begin
        // reset state: all-zero inputs decode as add of zeros (R1, R2)
        repeat (2) @(negedge clk);
        #1;
        check(1, 8'h00, 1'b1, 8'h40);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            drive(VEC[i][45:42], VEC[i][41:34], VEC[i][33:26], VEC[i][25], VEC[i][24:17]);
            check(int'(VEC[i][49:46]), VEC[i][16:9], VEC[i][8], VEC[i][7:0]);
        end

        // R11: carry_i ignored by plain add and by decrement
        drive(4'd0, 8'h10, 8'h20, 1'b1, 8'h00);
        check(11, 8'h30, 1'b1, 8'h00);
        drive(4'd9, 8'h05, 8'h00, 1'b1, 8'h00);
        check(11, 8'h04, 1'b1, 8'h02);
        drive(4'd2, 8'h05, 8'h03, 1'b1, 8'h00);
        check(11, 8'h02, 1'b1, 8'h02);
        // R9: complement-carry with carry_i = 0
        drive(4'd13, 8'h00, 8'h00, 1'b0, 8'h00);
        check(9, 8'h00, 1'b0, 8'h01);
        // R4: compare flags match subtract for a borrowing pair
        drive(4'd4, 8'h80, 8'h01, 1'b0, 8'h00);
        check(4, 8'h80, 1'b0, 8'h16);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule